// File: doc/BRIEF.md
# SD Host Command and Status Unit

This unit is the command-issue half of a memory-mapped SD host controller. Software loads a 32-bit argument, then writes a 16-bit command word. If the word carries its start bit, the unit offers the 6-bit command index and the argument to the card side on a valid/ready request port. It then waits for the card's reply, which is a byte count, a 128-bit response bus and an error flag.

When the reply arrives, the unit compares the returned length with the response type the command asked for. It then either loads four 32-bit response words or reports a failure. A failure sets a fail bit in the command word and a command-timeout bit in status. A busy-wait command that completes cleanly can raise a busy interrupt, but only if configuration allows it. Status bits are cleared by writing ones to them. One interrupt line is high while any of the busy, block or SDIO status bits is set.

Register map (byte offsets): command 0x00, argument 0x04, response words 0x10/0x14/0x18/0x1C, status 0x20, configuration 0x38. Command word fields: bit 15 start, bit 14 fail, bit 11 busy-wait, bit 10 no response, bit 9 long response, bit 7 write, bit 6 read, bits 5:0 index.

Top module: `sdcmd_top`

## Requirements
- R1: After reset the command, argument, response, status and configuration registers all read zero, the interrupt is low and no request is offered.
- R2: Writing the command register with bit 15 set raises `cardReqValid`, with `cardReqIndex` equal to bits 5:0 of the command word and `cardReqArg` equal to the argument register. Both are held stable until `cardReqReady` is seen. Bit 15 reads back as 1 while the command is outstanding.
- R3: Bit 15 of the command register clears on the cycle after the card response is accepted, and all other command bits read back as written. A command write with bit 15 clear is stored but issues no request.
- R4: Byte k of the response bus is `cardRspData[127-8k -: 8]`. On a clean 4-byte response, word 0 (0x10) takes bytes 0..3 with byte 0 in bits 31:24, and words 1..3 read zero.
- R5: On a clean 16-byte response, word 0 takes bytes 12..15, word 1 bytes 8..11, word 2 bytes 4..7 and word 3 bytes 0..3, each with its lowest-numbered byte in bits 31:24.
- R6: When a response is expected (bit 10 clear), a byte count of 0, a count of 4 with bit 9 set, any count other than 4 or 16, or an asserted `cardRspErr` sets command bit 14 and status bit 6 (0x40) and leaves the response words unchanged.
- R7: With bit 10 set, the byte count is not checked and the response words are left unchanged. Only `cardRspErr` can fail such a command.
- R8: A busy-wait command (bit 11) that completes without error sets status bit 10 (0x400) only when configuration bit 10 is set. A failed command never sets it.
- R9: A write to status (0x20) clears every bit written as 1 and keeps every bit written as 0.
- R10: `irq` is high exactly when any of status bits 10, 9 or 8 is set. Status bit 6 alone does not raise it.
- R11: Configuration (0x38) reads back what was written. Reads of undefined offsets return zero, and writes to them change no register.
- R12: While a command is outstanding, writes to the command and argument registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| cardReqValid | output | 1 | Command request offered to card side |
| cardReqReady | input | 1 | Card side accepts request |
| cardReqIndex | output | 6 | Command index |
| cardReqArg | output | 32 | Command argument |
| cardRspValid | input | 1 | Card response present (one cycle) |
| cardRspBytes | input | 5 | Response length in bytes |
| cardRspErr | input | 1 | Card reports the command could not run |
| cardRspData | input | 128 | Response bytes, byte 0 in the top byte |
| irq | output | 1 | Combined interrupt |

## Verification
The command path is driven with a clean short reply, a clean long reply, and a short reply that follows a long one. Between them, these show whether the short path clears the upper words and whether the long path reverses the word order. Four failure patterns are each applied separately: zero bytes, four bytes on a long request, an odd length, and the card error flag. This shows that every length rule triggers the fail and timeout bits on its own. A no-response command with a zero length shows that the length check is skipped. Busy-wait commands are run with the enable on and off, and with a failing reply, which separates the gating from the error path. Writes arriving while a command is in flight show that the request stays stable.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int OFF_CMD    = 'h00;
  localparam int OFF_ARG    = 'h04;
  localparam int OFF_RSP0   = 'h10;
  localparam int OFF_STATUS = 'h20;
  localparam int OFF_CFG    = 'h38;

  localparam int CMD_W       = 16;
  localparam int BIT_START   = 15;
  localparam int BIT_FAIL    = 14;
  localparam int BIT_BUSYWT  = 11;
  localparam int BIT_NORSP   = 10;
  localparam int BIT_LONG    = 9;
  localparam int INDEX_W     = 6;

  localparam int STATUS_W    = 11;
  localparam int ST_TIMEOUT  = 6;
  localparam int ST_BUSY     = 10;
  localparam int CFG_BUSY_EN = 10;
  localparam logic [STATUS_W-1:0] IRQ_MASK = 11'h700;

  typedef struct packed {
    logic complete;
    logic fail;
    logic loadShort;
    logic loadLong;
    logic setBusy;
  } sdcmd_strobe_t;
endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int BYTES_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdLaunch,
  input  logic               cmdNoRsp,
  input  logic               cmdLong,
  input  logic               cmdBusyWait,
  input  logic               busyIrqEn,
  input  logic               cardReqReady,
  input  logic               cardRspValid,
  input  logic [BYTES_W-1:0] cardRspBytes,
  input  logic               cardRspErr,
  output logic               cardReqValid,
  output logic               busy,
  output sdcmd_strobe_t      strobe
);
  localparam logic [BYTES_W-1:0] LEN_SHORT = BYTES_W'(4);
  localparam logic [BYTES_W-1:0] LEN_LONG  = BYTES_W'(16);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_AWAIT} ctrl_state_t;
  ctrl_state_t state;

  logic rspDone, lenBad, cmdErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (cmdLaunch) state <= ST_ISSUE;
        ST_ISSUE: if (cardReqReady) state <= ST_AWAIT;
        ST_AWAIT: if (cardRspValid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cardReqValid = (state == ST_ISSUE);
    busy         = (state != ST_IDLE);
    rspDone      = (state == ST_AWAIT) && cardRspValid;
    lenBad       = (cardRspBytes == '0)
                 || (cardRspBytes == LEN_SHORT && cmdLong)
                 || (cardRspBytes != LEN_SHORT && cardRspBytes != LEN_LONG);
    cmdErr       = cardRspErr || (!cmdNoRsp && lenBad);
    strobe.complete  = rspDone;
    strobe.fail      = rspDone && cmdErr;
    strobe.loadShort = rspDone && !cmdErr && !cmdNoRsp && cardRspBytes == LEN_SHORT;
    strobe.loadLong  = rspDone && !cmdErr && !cmdNoRsp && cardRspBytes == LEN_LONG;
    strobe.setBusy   = rspDone && !cmdErr && cmdBusyWait && busyIrqEn;
  end
endmodule

// File: rtl/sdcmd_datapath.sv
module sdcmd_datapath
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WORD_W    = 32,
  parameter int RSP_WORDS = 4,
  localparam int RSP_W    = WORD_W * RSP_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              busy,
  input  sdcmd_strobe_t     strobe,
  input  logic [RSP_W-1:0]  cardRspData,
  output logic              cmdLaunch,
  output logic [CMD_W-1:0]  cmdWord,
  output logic [WORD_W-1:0] argWord,
  output logic [WORD_W-1:0] cfgWord,
  output logic [STATUS_W-1:0] statusWord,
  output logic              irq
);
  logic [RSP_WORDS-1:0][WORD_W-1:0] rspReg;
  logic [RSP_WORDS-1:0][WORD_W-1:0] rspLong;
  logic [RSP_WORDS-1:0][WORD_W-1:0] rspShort;
  logic cmdWrHit, argWrHit, cfgWrHit, stWrHit;
  logic [STATUS_W-1:0] stClear, stSet;

  assign cmdWrHit  = regWrEn && regAddr == ADDR_W'(OFF_CMD) && !busy;
  assign argWrHit  = regWrEn && regAddr == ADDR_W'(OFF_ARG) && !busy;
  assign cfgWrHit  = regWrEn && regAddr == ADDR_W'(OFF_CFG);
  assign stWrHit   = regWrEn && regAddr == ADDR_W'(OFF_STATUS);
  assign cmdLaunch = cmdWrHit && regWrData[BIT_START];

  // word i of the long form is the i-th lowest slice of the response bus
  for (genvar i = 0; i < RSP_WORDS; i++) begin : g_rsp
    assign rspLong[i] = cardRspData[WORD_W*i +: WORD_W];
    if (i == 0) begin : g_first
      assign rspShort[i] = cardRspData[RSP_W-1 -: WORD_W];
    end else begin : g_rest
      assign rspShort[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspReg <= '0;
    end else if (strobe.loadLong) begin
      rspReg <= rspLong;
    end else if (strobe.loadShort) begin
      rspReg <= rspShort;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWord <= '0;
    end else if (cmdWrHit) begin
      cmdWord <= regWrData[CMD_W-1:0];
    end else if (strobe.complete) begin
      cmdWord[BIT_START] <= 1'b0;
      if (strobe.fail) cmdWord[BIT_FAIL] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      argWord <= '0;
      cfgWord <= '0;
    end else begin
      if (argWrHit) argWord <= regWrData;
      if (cfgWrHit) cfgWord <= regWrData;
    end
  end

  always_comb begin
    stClear = stWrHit ? regWrData[STATUS_W-1:0] : '0;
    stSet   = '0;
    stSet[ST_TIMEOUT] = strobe.fail;
    stSet[ST_BUSY]    = strobe.setBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusWord <= '0;
    else       statusWord <= (statusWord & ~stClear) | stSet;
  end

  assign irq = |(statusWord & IRQ_MASK);

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(OFF_CMD))    regRdData = WORD_W'(cmdWord);
    if (regAddr == ADDR_W'(OFF_ARG))    regRdData = argWord;
    if (regAddr == ADDR_W'(OFF_STATUS)) regRdData = WORD_W'(statusWord);
    if (regAddr == ADDR_W'(OFF_CFG))    regRdData = cfgWord;
    for (int i = 0; i < RSP_WORDS; i++) begin
      if (regAddr == ADDR_W'(OFF_RSP0 + 4 * i)) regRdData = rspReg[i];
    end
  end
endmodule

// File: rtl/sdcmd_top.sv
module sdcmd_top
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WORD_W    = 32,
  parameter int RSP_WORDS = 4,
  parameter int BYTES_W   = 5,
  localparam int RSP_W    = WORD_W * RSP_WORDS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [WORD_W-1:0]  regWrData,
  output logic [WORD_W-1:0]  regRdData,
  output logic               cardReqValid,
  input  logic               cardReqReady,
  output logic [INDEX_W-1:0] cardReqIndex,
  output logic [WORD_W-1:0]  cardReqArg,
  input  logic               cardRspValid,
  input  logic [BYTES_W-1:0] cardRspBytes,
  input  logic               cardRspErr,
  input  logic [RSP_W-1:0]   cardRspData,
  output logic               irq
);
  sdcmd_strobe_t       strobe;
  logic                busy;
  logic                cmdLaunch;
  logic [CMD_W-1:0]    cmdWord;
  logic [WORD_W-1:0]   cfgWord;
  logic [STATUS_W-1:0] statusWord;

  sdcmd_ctrl #(.BYTES_W(BYTES_W)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .cmdLaunch    (cmdLaunch),
    .cmdNoRsp     (cmdWord[BIT_NORSP]),
    .cmdLong      (cmdWord[BIT_LONG]),
    .cmdBusyWait  (cmdWord[BIT_BUSYWT]),
    .busyIrqEn    (cfgWord[CFG_BUSY_EN]),
    .cardReqReady (cardReqReady),
    .cardRspValid (cardRspValid),
    .cardRspBytes (cardRspBytes),
    .cardRspErr   (cardRspErr),
    .cardReqValid (cardReqValid),
    .busy         (busy),
    .strobe       (strobe)
  );

  sdcmd_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RSP_WORDS(RSP_WORDS)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .busy        (busy),
    .strobe      (strobe),
    .cardRspData (cardRspData),
    .cmdLaunch   (cmdLaunch),
    .cmdWord     (cmdWord),
    .argWord     (cardReqArg),
    .cfgWord     (cfgWord),
    .statusWord  (statusWord),
    .irq         (irq)
  );

  assign cardReqIndex = cmdWord[INDEX_W-1:0];
endmodule

// File: rtl/sdcmd_checks.sv
module sdcmd_checks
  import sdcmd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                cardReqValid,
  input logic                cardReqReady,
  input logic [INDEX_W-1:0]  cardReqIndex,
  input logic [WORD_W-1:0]   cardReqArg,
  input logic                cardRspValid,
  input logic                irq,
  input logic                busy,
  input logic [CMD_W-1:0]    cmdWord,
  input logic [WORD_W-1:0]   cfgWord,
  input logic [STATUS_W-1:0] statusWord
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cardReqValid && !cardReqReady |=> cardReqValid && $stable(cardReqIndex) && $stable(cardReqArg)); // R2
  AST_REQ_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    cardReqValid |-> cmdWord[BIT_START]); // R2
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    busy && !cardReqValid && cardRspValid |=> !cmdWord[BIT_START]); // R3
  AST_FAIL_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdWord[BIT_FAIL]) && $past(busy) |-> statusWord[ST_TIMEOUT]); // R6
  AST_BUSY_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[ST_BUSY]) |-> $past(cfgWord[CFG_BUSY_EN])); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(cardRspValid && busy)); // R10
endmodule

bind sdcmd_top sdcmd_checks #(.WORD_W(WORD_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .cardReqValid (cardReqValid),
  .cardReqReady (cardReqReady),
  .cardReqIndex (cardReqIndex),
  .cardReqArg   (cardReqArg),
  .cardRspValid (cardRspValid),
  .irq          (irq),
  .busy         (busy),
  .cmdWord      (cmdWord),
  .cfgWord      (cfgWord),
  .statusWord   (statusWord)
);

// File: tb/sdcmd_tb.sv
module sdcmd_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [7:0]   regAddr = '0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic         cardReqValid;
  logic         cardReqReady = 1'b0;
  logic [5:0]   cardReqIndex;
  logic [31:0]  cardReqArg;
  logic         cardRspValid = 1'b0;
  logic [4:0]   cardRspBytes = '0;
  logic         cardRspErr = 1'b0;
  logic [127:0] cardRspData = '0;
  logic         irq;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  localparam logic [127:0] DATA_A = 128'h0A0B0C0D_1A1B1C1D_2A2B2C2D_3A3B3C3D;
  localparam logic [127:0] DATA_B = 128'h11223344_55667788_99AABBCC_DDEEFF00;

  sdcmd_top dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic checkReg(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rdReg(a, v);
    check(req, $sformatf("reg %02h", a), v, exp);
  endtask

  task automatic checkRsp(string req, logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, logic [31:0] w3);
    checkReg(req, 8'h10, w0);
    checkReg(req, 8'h14, w1);
    checkReg(req, 8'h18, w2);
    checkReg(req, 8'h1C, w3);
  endtask

  // issue a command, let the card accept after two waits, answer, return at the negedge after update
  task automatic runCmd(logic [31:0] arg, logic [15:0] cmd, logic [4:0] nBytes,
                        logic [127:0] data, logic err);
    wrReg(8'h04, arg);
    wrReg(8'h00, {16'h0, cmd});
    check("R2", "request valid", {31'b0, cardReqValid}, 32'd1);
    check("R2", "request index", {26'b0, cardReqIndex}, {26'b0, cmd[5:0]});
    check("R2", "request argument", cardReqArg, arg);
    checkReg("R2", 8'h00, {16'h0, cmd});
    @(negedge clk);
    @(negedge clk);
    check("R2", "valid held", {31'b0, cardReqValid}, 32'd1);
    cardReqReady = 1'b1;
    @(negedge clk);
    cardReqReady = 1'b0;
    check("R2", "valid dropped", {31'b0, cardReqValid}, 32'd0);
    cardRspValid = 1'b1; cardRspBytes = nBytes; cardRspData = data; cardRspErr = err;
    @(negedge clk);
    cardRspValid = 1'b0; cardRspErr = 1'b0;
  endtask

  task automatic tReset();
    check("R1", "irq", {31'b0, irq}, 32'd0);
    check("R1", "request", {31'b0, cardReqValid}, 32'd0);
    checkReg("R1", 8'h00, 0);
    checkReg("R1", 8'h04, 0);
    checkReg("R1", 8'h20, 0);
    checkReg("R1", 8'h38, 0);
    checkRsp("R1", 0, 0, 0, 0);
  endtask

  task automatic tLongThenShort();
    runCmd(32'hCAFE0001, 16'h8202, 5'd16, DATA_A, 1'b0);
    checkRsp("R5", 32'h3A3B3C3D, 32'h2A2B2C2D, 32'h1A1B1C1D, 32'h0A0B0C0D);
    checkReg("R3", 8'h00, 32'h0000_0202);
    runCmd(32'hA5A51234, 16'h80D1, 5'd4, DATA_B, 1'b0);
    checkRsp("R4", 32'h11223344, 0, 0, 0);
    checkReg("R3", 8'h00, 32'h0000_00D1);
    checkReg("R6", 8'h20, 0);
  endtask

  task automatic tErrors();
    runCmd(32'h1, 16'h8203, 5'd4, DATA_A, 1'b0);
    checkReg("R6", 8'h00, 32'h0000_4203);
    checkReg("R6", 8'h20, 32'h40);
    check("R10", "timeout alone no irq", {31'b0, irq}, 32'd0);
    checkRsp("R6", 32'h11223344, 0, 0, 0);
    wrReg(8'h20, 32'h40);
    runCmd(32'h2, 16'h8004, 5'd0, DATA_A, 1'b0);
    checkReg("R6", 8'h00, 32'h0000_4004);
    checkReg("R6", 8'h20, 32'h40);
    wrReg(8'h20, 32'h40);
    runCmd(32'h3, 16'h8005, 5'd8, DATA_A, 1'b0);
    checkReg("R6", 8'h20, 32'h40);
    checkRsp("R6", 32'h11223344, 0, 0, 0);
    wrReg(8'h20, 32'h40);
    runCmd(32'h4, 16'h8006, 5'd4, DATA_A, 1'b1);
    checkReg("R6", 8'h00, 32'h0000_4006);
    checkReg("R6", 8'h20, 32'h40);
    checkRsp("R6", 32'h11223344, 0, 0, 0);
    wrReg(8'h20, 32'h40);
  endtask

  task automatic tNoRsp();
    runCmd(32'h5, 16'h8405, 5'd0, DATA_A, 1'b0);
    checkReg("R7", 8'h00, 32'h0000_0405);
    checkReg("R7", 8'h20, 0);
    checkRsp("R7", 32'h11223344, 0, 0, 0);
  endtask

  task automatic tBusy();
    wrReg(8'h38, 32'h0000_0400);
    checkReg("R11", 8'h38, 32'h0000_0400);
    runCmd(32'h7, 16'h8C07, 5'd0, DATA_A, 1'b0);
    checkReg("R8", 8'h20, 32'h400);
    check("R10", "irq with busy", {31'b0, irq}, 32'd1);
    wrReg(8'h20, 32'h0000_00BF);
    checkReg("R9", 8'h20, 32'h400);
    check("R10", "irq kept", {31'b0, irq}, 32'd1);
    wrReg(8'h20, 32'h0000_0400);
    checkReg("R9", 8'h20, 0);
    check("R10", "irq cleared", {31'b0, irq}, 32'd0);
    runCmd(32'h8, 16'h8808, 5'd0, DATA_A, 1'b0);
    checkReg("R8", 8'h20, 32'h40);
    check("R8", "no irq on failed busy", {31'b0, irq}, 32'd0);
    wrReg(8'h20, 32'h40);
    wrReg(8'h38, 32'h0);
    runCmd(32'h9, 16'h8C09, 5'd0, DATA_A, 1'b0);
    checkReg("R8", 8'h20, 0);
    check("R8", "gated irq", {31'b0, irq}, 32'd0);
  endtask

  task automatic tNoStart();
    wrReg(8'h00, 32'h0000_0243);
    @(negedge clk);
    check("R3", "no request", {31'b0, cardReqValid}, 32'd0);
    checkReg("R3", 8'h00, 32'h0000_0243);
  endtask

  task automatic tUndef();
    wrReg(8'h24, 32'hFFFF_FFFF);
    wrReg(8'h08, 32'h1234_5678);
    checkReg("R11", 8'h24, 0);
    checkReg("R11", 8'h08, 0);
    checkReg("R11", 8'h00, 32'h0000_0243);
    checkReg("R11", 8'h20, 0);
    checkReg("R11", 8'h38, 0);
  endtask

  task automatic tBusyIgnore();
    wrReg(8'h04, 32'h0BAD_F00D);
    wrReg(8'h00, 32'h0000_800C);
    wrReg(8'h00, 32'h0000_8409);
    wrReg(8'h04, 32'hDEAD_BEEF);
    check("R12", "index kept", {26'b0, cardReqIndex}, 32'd12);
    check("R12", "argument kept", cardReqArg, 32'h0BAD_F00D);
    cardReqReady = 1'b1;
    @(negedge clk);
    cardReqReady = 1'b0;
    cardRspValid = 1'b1; cardRspBytes = 5'd4; cardRspData = DATA_A;
    @(negedge clk);
    cardRspValid = 1'b0;
    checkReg("R12", 8'h00, 32'h0000_000C);
    checkReg("R12", 8'h04, 32'h0BAD_F00D);
    checkRsp("R4", 32'h0A0B0C0D, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLongThenShort();
    tErrors();
    tNoRsp();
    tBusy();
    tNoStart();
    tUndef();
    tBusyIgnore();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule